// File: doc/BRIEF.md
# Configurable Set/Reset Register Slice

This block holds eight storage bits plus a ninth carry bit, as found behind the lookup tables of a programmable logic cell. Each of the eight main bits can act as a rising-edge flip-flop or as a transparent latch. Static configuration words choose, for every bit, where its data comes from: a tie-off constant, its lookup-table output, its direct input, or a run-time pick between those two driven by a shared select line. Each bit also carries its own set/reset value, which is the value that both the local and the global set/reset force it to.

The local set/reset may act asynchronously, or on the clock edge. In the clocked case a further option decides whether it needs the clock enable or overrides it. The active-low global set/reset is always asynchronous, and one configuration bit can make the slice ignore it. The ninth bit is a flip-flop only. It loads constant 0, constant 1, the carry input or the arithmetic carry-out, and it shares the enable and set/reset behaviour of the other bits.

Top module: `srr_slice`

## Requirements
- R1: While rst_ni is low and cfg_gsr_off_i is 0, every q_o bit equals its cfg_srval_i bit and q9_o equals cfg_c9_srval_i at once, without waiting for a clock edge, and this holds across clock edges.
- R2: With cfg_gsr_off_i at 1, a low rst_ni has no effect: the bits keep loading data on clock edges.
- R3: Per-bit source code cfg_src_i[i] is 0 for the tie constant, 1 for lut_i[i], 2 for din_i[i], and 3 for a pick where sel_i=0 chooses lut_i[i] and sel_i=1 chooses din_i[i]. In flip-flop mode the chosen value appears on q_o[i] after the next rising clock edge with ce_i high.
- R4: Source code 0 loads cfg_tie_i[i], so each bit has its own tie-off constant.
- R5: In flip-flop mode, a rising edge with ce_i low and no set/reset leaves q_o and q9_o unchanged.
- R6: With cfg_lsr_async_i=0 and cfg_lsr_over_ce_i=0, a high lsr_i loads the set/reset values on an edge only when ce_i is high; with ce_i low the bits hold.
- R7: With cfg_lsr_async_i=0 and cfg_lsr_over_ce_i=1, a high lsr_i loads the set/reset values on the next edge whatever ce_i is.
- R8: With cfg_lsr_async_i=1, a high lsr_i forces q_o to cfg_srval_i and q9_o to cfg_c9_srval_i at once and holds them across clock edges. After lsr_i falls, the next enabled edge loads data again.
- R9: A bit with cfg_latch_i[i]=1 passes its source to q_o[i] while clk_i is high and holds while clk_i is low, whatever ce_i is.
- R10: In latch mode, a clocked lsr_i has no effect while clk_i is low. While clk_i is high it forces the bit to its set/reset value.
- R11: The ninth bit's source cfg_c9_src_i is 0 for constant 0, 1 for constant 1, 2 for cin_i and 3 for cout_i. It is always a flip-flop and never becomes transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the gate of latch-mode bits |
| rst_ni | input | 1 | Global set/reset, active low, asynchronous |
| ce_i | input | 1 | Clock enable for flip-flop-mode bits |
| lsr_i | input | 1 | Local set/reset, active high |
| sel_i | input | 1 | Run-time pick between lut_i and din_i |
| lut_i | input | 8 | Lookup-table outputs, one per bit |
| din_i | input | 8 | Direct data inputs, one per bit |
| cin_i | input | 1 | Carry input, source option for the ninth bit |
| cout_i | input | 1 | Arithmetic carry-out, source option for the ninth bit |
| cfg_src_i | input | 16 | Two-bit source code per main bit |
| cfg_tie_i | input | 8 | Tie-off constant per bit |
| cfg_srval_i | input | 8 | Set/reset value per bit |
| cfg_latch_i | input | 8 | 1 makes the bit a latch |
| cfg_lsr_async_i | input | 1 | 1 makes lsr_i asynchronous |
| cfg_lsr_over_ce_i | input | 1 | 1 lets a clocked lsr_i override ce_i |
| cfg_gsr_off_i | input | 1 | 1 makes the slice ignore rst_ni |
| cfg_c9_src_i | input | 2 | Ninth-bit source code |
| cfg_c9_srval_i | input | 1 | Ninth-bit set/reset value |
| q_o | output | 8 | Main storage outputs |
| q9_o | output | 1 | Ninth flip-flop output |

## Verification
Flip-flop results are due one rising edge after the stimulus. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, so exactly one capture edge lies between. Asynchronous set/reset is due within the same time step. It is raised 1 ns after a falling edge and checked 1 ns later, before any rising edge can mask a late response, and then checked again after an edge to show that it holds. Latch results are checked 2 ns into each clock phase: in the high phase to show the latch is transparent, in the low phase to show it holds, and alongside the ninth bit to show that bit does not follow its input.

// File: rtl/srr_pkg.sv
package srr_pkg;

  typedef enum logic [1:0] {
    SRC_TIE  = 2'd0,
    SRC_LUT  = 2'd1,
    SRC_DIN  = 2'd2,
    SRC_PICK = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    C9_ZERO = 2'd0,
    C9_ONE  = 2'd1,
    C9_CIN  = 2'd2,
    C9_COUT = 2'd3
  } c9_src_e;

endpackage

// File: rtl/srr_src_mux.sv
module srr_src_mux (
  input  logic [1:0] src_i,
  input  logic       tie_i,
  input  logic       lut_i,
  input  logic       din_i,
  input  logic       sel_i,
  output logic       d_o
);
  import srr_pkg::*;

  always_comb begin
    unique case (src_e'(src_i))
      SRC_TIE:  d_o = tie_i;
      SRC_LUT:  d_o = lut_i;
      SRC_DIN:  d_o = din_i;
      SRC_PICK: d_o = sel_i ? din_i : lut_i;
      default:  d_o = tie_i;
    endcase
  end
endmodule

// File: rtl/srr_ff.sv
module srr_ff (
  input  logic clk_i,
  input  logic force_i,    // async load of srval
  input  logic sync_lsr_i,
  input  logic over_ce_i,
  input  logic ce_i,
  input  logic d_i,
  input  logic srval_i,
  output logic q_o
);
  logic nxt;

  // enable mux with set/reset priority chosen by over_ce_i
  always_comb begin
    if (sync_lsr_i && (over_ce_i || ce_i)) nxt = srval_i;
    else if (ce_i)                         nxt = d_i;
    else                                   nxt = q_o;
  end

  always_ff @(posedge clk_i or posedge force_i) begin
    if (force_i) q_o <= srval_i;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/srr_latch.sv
module srr_latch (
  input  logic gate_i,
  input  logic force_i,
  input  logic sync_lsr_i,
  input  logic d_i,
  input  logic srval_i,
  output logic q_o
);
  always_latch begin
    if (force_i)     q_o <= srval_i;
    else if (gate_i) q_o <= sync_lsr_i ? srval_i : d_i;
  end
endmodule

// File: rtl/srr_slice.sv
module srr_slice #(
  parameter int WIDTH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_i,
  input  logic                  lsr_i,
  input  logic                  sel_i,
  input  logic [WIDTH-1:0]      lut_i,
  input  logic [WIDTH-1:0]      din_i,
  input  logic                  cin_i,
  input  logic                  cout_i,
  input  logic [WIDTH-1:0][1:0] cfg_src_i,
  input  logic [WIDTH-1:0]      cfg_tie_i,
  input  logic [WIDTH-1:0]      cfg_srval_i,
  input  logic [WIDTH-1:0]      cfg_latch_i,
  input  logic                  cfg_lsr_async_i,
  input  logic                  cfg_lsr_over_ce_i,
  input  logic                  cfg_gsr_off_i,
  input  logic [1:0]            cfg_c9_src_i,
  input  logic                  cfg_c9_srval_i,
  output logic [WIDTH-1:0]      q_o,
  output logic                  q9_o
);
  import srr_pkg::*;

  logic gsr_act;
  logic force_sr;
  logic sync_lsr;
  logic d9;

  assign gsr_act  = ~rst_ni & ~cfg_gsr_off_i;
  assign force_sr = gsr_act | (lsr_i & cfg_lsr_async_i);
  assign sync_lsr = lsr_i & ~cfg_lsr_async_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic d;
    logic ff_q;
    logic lat_q;

    srr_src_mux u_mux (
      .src_i (cfg_src_i[i]),
      .tie_i (cfg_tie_i[i]),
      .lut_i (lut_i[i]),
      .din_i (din_i[i]),
      .sel_i (sel_i),
      .d_o   (d)
    );

    srr_ff u_ff (
      .clk_i      (clk_i),
      .force_i    (force_sr),
      .sync_lsr_i (sync_lsr),
      .over_ce_i  (cfg_lsr_over_ce_i),
      .ce_i       (ce_i),
      .d_i        (d),
      .srval_i    (cfg_srval_i[i]),
      .q_o        (ff_q)
    );

    srr_latch u_lat (
      .gate_i     (clk_i),
      .force_i    (force_sr),
      .sync_lsr_i (sync_lsr),
      .d_i        (d),
      .srval_i    (cfg_srval_i[i]),
      .q_o        (lat_q)
    );

    assign q_o[i] = cfg_latch_i[i] ? lat_q : ff_q;
  end

  always_comb begin
    unique case (c9_src_e'(cfg_c9_src_i))
      C9_ZERO: d9 = 1'b0;
      C9_ONE:  d9 = 1'b1;
      C9_CIN:  d9 = cin_i;
      C9_COUT: d9 = cout_i;
      default: d9 = 1'b0;
    endcase
  end

  // ninth bit: flip-flop only, no front-end pick
  srr_ff u_ff9 (
    .clk_i      (clk_i),
    .force_i    (force_sr),
    .sync_lsr_i (sync_lsr),
    .over_ce_i  (cfg_lsr_over_ce_i),
    .ce_i       (ce_i),
    .d_i        (d9),
    .srval_i    (cfg_c9_srval_i),
    .q_o        (q9_o)
  );
endmodule

// File: rtl/srr_slice_chk.sv
module srr_slice_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             lsr_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] cfg_srval_i,
  input logic [WIDTH-1:0] cfg_latch_i,
  input logic             cfg_lsr_async_i,
  input logic             cfg_lsr_over_ce_i,
  input logic [1:0]       cfg_c9_src_i,
  input logic             cfg_c9_srval_i,
  input logic [WIDTH-1:0] q_o,
  input logic             q9_o
);
  // R5
  ff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !lsr_i) |=>
      (lsr_i || ((((q_o ^ $past(q_o)) & ~cfg_latch_i & ~$past(cfg_latch_i)) == '0)
                 && q9_o == $past(q9_o))));

  // R6
  lsr_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_i && !ce_i && !cfg_lsr_async_i && !cfg_lsr_over_ce_i) |=>
      ((((q_o ^ $past(q_o)) & ~cfg_latch_i & ~$past(cfg_latch_i)) == '0)
       && q9_o == $past(q9_o)));

  // R7
  lsr_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_i && !cfg_lsr_async_i && cfg_lsr_over_ce_i) |=>
      ((((q_o ^ $past(cfg_srval_i)) & ~$past(cfg_latch_i)) == '0)
       && q9_o == $past(cfg_c9_srval_i)));

  // R8
  lsr_async_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_i && cfg_lsr_async_i) |-> (q_o == cfg_srval_i && q9_o == cfg_c9_srval_i));

  // R11
  c9_cin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lsr_i && ce_i && cfg_c9_src_i == 2'd2) |=> (lsr_i || q9_o == $past(cin_i)));
endmodule

bind srr_slice srr_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .ce_i              (ce_i),
  .lsr_i             (lsr_i),
  .cin_i             (cin_i),
  .cfg_srval_i       (cfg_srval_i),
  .cfg_latch_i       (cfg_latch_i),
  .cfg_lsr_async_i   (cfg_lsr_async_i),
  .cfg_lsr_over_ce_i (cfg_lsr_over_ce_i),
  .cfg_c9_src_i      (cfg_c9_src_i),
  .cfg_c9_srval_i    (cfg_c9_srval_i),
  .q_o               (q_o),
  .q9_o              (q9_o)
);

// File: tb/tb_srr_slice.sv
`timescale 1ns/1ps
module tb_srr_slice;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         ce_i, lsr_i, sel_i, cin_i, cout_i;
  logic [W-1:0] lut_i, din_i;
  logic [2*W-1:0] cfg_src_i;
  logic [W-1:0] cfg_tie_i, cfg_srval_i, cfg_latch_i;
  logic         cfg_lsr_async_i, cfg_lsr_over_ce_i, cfg_gsr_off_i;
  logic [1:0]   cfg_c9_src_i;
  logic         cfg_c9_srval_i;
  logic [W-1:0] q_o;
  logic         q9_o;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  always #4 clk_i = ~clk_i;

  srr_slice #(.WIDTH(W)) dut (
    .clk_i, .rst_ni, .ce_i, .lsr_i, .sel_i, .lut_i, .din_i, .cin_i, .cout_i,
    .cfg_src_i, .cfg_tie_i, .cfg_srval_i, .cfg_latch_i, .cfg_lsr_async_i,
    .cfg_lsr_over_ce_i, .cfg_gsr_off_i, .cfg_c9_src_i, .cfg_c9_srval_i,
    .q_o, .q9_o
  );

  typedef struct packed {
    logic [15:0] src;
    logic        sel;
    logic [7:0]  lut;
    logic [7:0]  din;
    logic        ce;
    logic        lsr;
    logic        over;
    logic [1:0]  c9;
    logic        cin;
    logic        cout;
    logic [7:0]  exp_q;
    logic        exp_q9;
  } vec_t;

  // srval = 5A, tie = 0F, c9 srval = 1; flip-flop mode, clocked lsr
  localparam vec_t VEC [12] = '{
    '{16'h5555, 1'b0, 8'hC3, 8'h3C, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 8'hC3, 1'b1},
    '{16'hAAAA, 1'b0, 8'hC3, 8'h3C, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 8'h3C, 1'b0},
    '{16'hFFFF, 1'b0, 8'h81, 8'h3C, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'h81, 1'b1},
    '{16'hFFFF, 1'b1, 8'h81, 8'h7E, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'h7E, 1'b0},
    '{16'h0000, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'h0F, 1'b0},
    '{16'h5555, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 8'h0F, 1'b0},
    '{16'h5555, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h5A, 1'b1},
    '{16'h5555, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'h00, 1'b0},
    '{16'h5555, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 8'h00, 1'b0},
    '{16'h5555, 1'b0, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h5A, 1'b1},
    '{16'hAA55, 1'b0, 8'h12, 8'h34, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 8'h32, 1'b0},
    '{16'hAA55, 1'b1, 8'hAB, 8'hCD, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 8'hCB, 1'b1}
  };

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s q_o actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s q9_o actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic prev9;
    rst_ni = 1'b0;
    ce_i = 1'b0; lsr_i = 1'b0; sel_i = 1'b0; cin_i = 1'b0; cout_i = 1'b0;
    lut_i = '0; din_i = '0;
    cfg_src_i = '0; cfg_tie_i = 8'h0F; cfg_srval_i = 8'h5A; cfg_latch_i = '0;
    cfg_lsr_async_i = 1'b0; cfg_lsr_over_ce_i = 1'b0; cfg_gsr_off_i = 1'b0;
    cfg_c9_src_i = 2'd0; cfg_c9_srval_i = 1'b1;

    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk8("R1 reset", q_o, 8'h5A);
    chk1("R1 reset", q9_o, 1'b1);
    rst_ni = 1'b1;

    // vector table: R3 R4 R5 R6 R7 R11
    foreach (VEC[k]) begin
      @(negedge clk_i);
      cfg_src_i = VEC[k].src; sel_i = VEC[k].sel; lut_i = VEC[k].lut; din_i = VEC[k].din;
      ce_i = VEC[k].ce; lsr_i = VEC[k].lsr; cfg_lsr_over_ce_i = VEC[k].over;
      cfg_c9_src_i = VEC[k].c9; cin_i = VEC[k].cin; cout_i = VEC[k].cout;
      @(negedge clk_i);
      chk8($sformatf("R3/R4/R5/R6/R7 vec%0d", k), q_o, VEC[k].exp_q);
      chk1($sformatf("R11 vec%0d", k), q9_o, VEC[k].exp_q9);
    end

    // R8 asynchronous local set/reset
    lsr_i = 1'b0; cfg_lsr_over_ce_i = 1'b0; cfg_lsr_async_i = 1'b1;
    ce_i = 1'b1; cfg_src_i = 16'h5555; lut_i = 8'h00; cfg_c9_src_i = 2'd0;
    @(negedge clk_i);
    chk8("R8 pre", q_o, 8'h00);
    #1 lsr_i = 1'b1;
    #1 chk8("R8 immediate", q_o, 8'h5A);
    chk1("R8 immediate", q9_o, 1'b1);
    @(negedge clk_i);
    chk8("R8 held over edge", q_o, 8'h5A);
    lsr_i = 1'b0;
    @(negedge clk_i);
    chk8("R8 release", q_o, 8'h00);
    chk1("R8 release", q9_o, 1'b0);
    cfg_lsr_async_i = 1'b0;

    // R2 global set/reset disabled
    cfg_gsr_off_i = 1'b1; lut_i = 8'h66;
    #1 rst_ni = 1'b0;
    #1 chk8("R2 no immediate effect", q_o, 8'h00);
    @(negedge clk_i);
    chk8("R2 ignored", q_o, 8'h66);
    rst_ni = 1'b1; cfg_gsr_off_i = 1'b0;

    // R1 asynchronous global set/reset
    #1 rst_ni = 1'b0;
    #1 chk8("R1 immediate", q_o, 8'h5A);
    chk1("R1 immediate", q9_o, 1'b1);
    @(negedge clk_i);
    chk8("R1 held over edge", q_o, 8'h5A);
    rst_ni = 1'b1;

    // R9 R10 R11 latch mode
    cfg_latch_i = 8'hFF; ce_i = 1'b1; cfg_c9_src_i = 2'd2; cin_i = 1'b0;
    @(negedge clk_i);
    @(posedge clk_i);
    prev9 = q9_o;
    #1 lut_i = 8'h99; cin_i = ~prev9;
    #1 chk8("R9 transparent", q_o, 8'h99);
    chk1("R11 ninth not transparent", q9_o, prev9);
    @(negedge clk_i);
    ce_i = 1'b0;
    #1 lut_i = 8'h11;
    #1 chk8("R9 hold gate low", q_o, 8'h99);
    @(posedge clk_i);
    #2 chk8("R9 ce ignored", q_o, 8'h11);
    @(negedge clk_i);
    #1 lsr_i = 1'b1;
    #1 chk8("R10 gate low no effect", q_o, 8'h11);
    @(posedge clk_i);
    #2 chk8("R10 gate high", q_o, 8'h5A);
    @(negedge clk_i);
    lsr_i = 1'b0; cfg_latch_i = '0;
    @(negedge clk_i);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule